// File: doc/BRIEF.md
# Pipeline Hazard Detection and Operand Forwarding Control

This block is the run-time interlock of a five-stage in-order pipeline: fetch, decode/read, ALU, memory and write-back. Each cycle it compares the two source register numbers of the instruction in decode against the destination registers of the three instructions ahead of it. From that comparison it produces, for each source, the select of the operand bypass mux. It also raises a one-cycle hold when a load sits directly in front of a consumer, and a flush with a fetch redirect when a branch in the ALU stage turns out taken.

The unit is purely combinational. It is placed next to the pipeline registers, and its outputs go to their enables and clears and to the bypass muxes. Because writes retire in program order at write-back, only read-after-write matches need action. Fetch runs on past every branch on the assumption that it is not taken. The two instructions fetched behind a taken branch are turned into no-ops.

Internally, an action decoder picks one of three actions each cycle. ACT_RUN is normal flow, with no condition present. ACT_HOLD is chosen when the load-use condition is present and no flush is pending. ACT_REDIRECT is chosen whenever a taken branch is in the ALU stage, and it outranks ACT_HOLD. There is no stored state: the action is chosen again every cycle.

Top module: `hzd_fwd_unit`

## Requirements
- R1: For each source, the bypass select is 0 (register file), 1 (ALU-stage result), 2 (memory-stage value) or 3 (write-back value). It names the stage whose valid, register-writing producer has a destination equal to that source.
- R2: When more than one stage matches a source, the youngest producer wins: ALU stage over memory stage over write-back.
- R3: A producer never matches if its stage valid bit is low, or if its op class does not write a register. Op classes are 0 nop, 1 reg-reg ALU, 2 reg-imm ALU, 3 load, 4 store, 5 branch, 6-7 undefined. Only classes 1, 2 and 3 write.
- R4: A source or destination of register 0 never produces a bypass or a stall.
- R5: A valid load in the ALU stage whose destination equals a source that the decode instruction reads raises pc_hold, ifid_hold and idex_bubble together.
- R6: A load in the memory stage causes no stall; its value is forwarded with select 2. A non-load in the ALU stage never causes a stall.
- R7: A taken branch flag, with a valid branch in the ALU stage, raises ifid_flush, idex_flush and pc_redirect together. It also forces pc_hold, ifid_hold and idex_bubble low.
- R8: The taken flag has no effect unless the ALU stage holds a valid instruction of class 5 (branch).
- R9: With the decode valid bit low, both selects are 0 and no hold is raised.
- R10: A source is compared only if the decode op class reads it. Classes 1, 4 and 5 read both sources; classes 2 and 3 read source 1 only; classes 0, 6 and 7 read none. A source that is not read gets select 0 and never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_op | input | 3 | Decode op class |
| id_src1 | input | REG_W | Decode source register 1 |
| id_src2 | input | REG_W | Decode source register 2 |
| ex_valid | input | 1 | ALU stage valid |
| ex_op | input | 3 | ALU stage op class |
| ex_dst | input | REG_W | ALU stage destination register |
| mem_valid | input | 1 | Memory stage valid |
| mem_op | input | 3 | Memory stage op class |
| mem_dst | input | REG_W | Memory stage destination register |
| wb_valid | input | 1 | Write-back stage valid |
| wb_op | input | 3 | Write-back stage op class |
| wb_dst | input | REG_W | Write-back stage destination register |
| ex_taken | input | 1 | Branch in ALU stage resolved taken |
| fwd_sel1 | output | 2 | Bypass select for source 1 |
| fwd_sel2 | output | 2 | Bypass select for source 2 |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze IF/ID register |
| idex_bubble | output | 1 | Load a no-op into ID/EX for a stall |
| ifid_flush | output | 1 | Load a no-op into IF/ID (wrong path) |
| idex_flush | output | 1 | Load a no-op into ID/EX (wrong path) |
| pc_redirect | output | 1 | Steer fetch to the branch target |

## Verification
The hardest situations to reach are the ones where several conditions overlap. One is three stages all naming the same register while some of them are invalid or non-writing. Another is a load-use match that coincides with a raised taken flag, where the flag must be ignored because the ALU-stage instruction is a load. The stimulus table builds these overlaps directly by setting every stage field in a single vector. A sweep over all register numbers then covers the register-0 exclusion, and a pass over the undefined op classes covers consumers that read no source.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_NOP    = 3'd0;
    localparam logic [OPC_W-1:0] OPC_ALU    = 3'd1;
    localparam logic [OPC_W-1:0] OPC_ALUI   = 3'd2;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 3'd3;
    localparam logic [OPC_W-1:0] OPC_STORE  = 3'd4;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 3'd5;

    // producer stages, youngest first: ALU, memory, write-back
    localparam int NUM_PROD = 3;
    localparam int SEL_W    = $clog2(NUM_PROD + 1);
    localparam int NUM_SRC  = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_MEM = 2'd2,
        FWD_WB  = 2'd3
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ACT_RUN      = 2'd0,
        ACT_HOLD     = 2'd1,
        ACT_REDIRECT = 2'd2
    } act_e;

    function automatic logic op_writes(input logic [OPC_W-1:0] op);
        return (op == OPC_ALU) || (op == OPC_ALUI) || (op == OPC_LOAD);
    endfunction

    function automatic logic op_reads1(input logic [OPC_W-1:0] op);
        return (op == OPC_ALU) || (op == OPC_ALUI) || (op == OPC_LOAD) ||
               (op == OPC_STORE) || (op == OPC_BRANCH);
    endfunction

    function automatic logic op_reads2(input logic [OPC_W-1:0] op);
        return (op == OPC_ALU) || (op == OPC_STORE) || (op == OPC_BRANCH);
    endfunction

endpackage

// File: rtl/hzd_prod_cmp.sv
module hzd_prod_cmp
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_live,
    input  logic             prod_valid,
    input  logic [OPC_W-1:0] prod_op,
    input  logic [REG_W-1:0] prod_dst,
    output logic             hit
);
    logic dst_nonzero;
    logic same_reg;

    always_comb begin
        dst_nonzero = (prod_dst != '0);
        same_reg    = (prod_dst == src);
        hit         = src_live && prod_valid && op_writes(prod_op) &&
                      dst_nonzero && same_reg;
    end
endmodule

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]                 src,
    input  logic                             src_live,
    input  logic [NUM_PROD-1:0]              prod_valid,
    input  logic [NUM_PROD-1:0][OPC_W-1:0]   prod_op,
    input  logic [NUM_PROD-1:0][REG_W-1:0]   prod_dst,
    output logic [SEL_W-1:0]                 sel
);
    logic [NUM_PROD-1:0] hits;

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_cmp
        hzd_prod_cmp #(.REG_W(REG_W)) u_cmp (
            .src        (src),
            .src_live   (src_live),
            .prod_valid (prod_valid[p]),
            .prod_op    (prod_op[p]),
            .prod_dst   (prod_dst[p]),
            .hit        (hits[p])
        );
    end

    // oldest first so a younger hit overrides
    always_comb begin
        sel = FWD_RF;
        for (int k = NUM_PROD - 1; k >= 0; k--) begin
            if (hits[k]) begin
                sel = SEL_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [NUM_SRC-1:0][REG_W-1:0] src,
    input  logic [NUM_SRC-1:0]            src_live,
    input  logic                          ex_valid,
    input  logic [OPC_W-1:0]              ex_op,
    input  logic [REG_W-1:0]              ex_dst,
    output logic                          load_use
);
    logic [NUM_SRC-1:0] dep;
    logic               ex_is_load;

    assign ex_is_load = ex_valid && (ex_op == OPC_LOAD) && (ex_dst != '0);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_dep
        assign dep[s] = src_live[s] && (src[s] == ex_dst);
    end

    assign load_use = ex_is_load && (|dep);
endmodule

// File: rtl/hzd_action_ctl.sv
module hzd_action_ctl
    import hzd_pkg::*;
(
    input  logic load_use,
    input  logic branch_flush,
    output logic pc_hold,
    output logic ifid_hold,
    output logic idex_bubble,
    output logic ifid_flush,
    output logic idex_flush,
    output logic pc_redirect
);
    act_e act;

    // action choice: a redirect outranks a hold
    always_comb begin
        if (branch_flush) begin
            act = ACT_REDIRECT;
        end else if (load_use) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_RUN;
        end
    end

    // outputs per action
    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        idex_flush  = 1'b0;
        pc_redirect = 1'b0;
        unique case (act)
            ACT_RUN: begin
            end
            ACT_HOLD: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            ACT_REDIRECT: begin
                ifid_flush  = 1'b1;
                idex_flush  = 1'b1;
                pc_redirect = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             id_valid,
    input  logic [2:0]       id_op,
    input  logic [REG_W-1:0] id_src1,
    input  logic [REG_W-1:0] id_src2,
    input  logic             ex_valid,
    input  logic [2:0]       ex_op,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_valid,
    input  logic [2:0]       mem_op,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_valid,
    input  logic [2:0]       wb_op,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             ex_taken,
    output logic [1:0]       fwd_sel1,
    output logic [1:0]       fwd_sel2,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             idex_flush,
    output logic             pc_redirect
);
    logic [NUM_SRC-1:0][REG_W-1:0]  src_num;
    logic [NUM_SRC-1:0]             src_live;
    logic [NUM_SRC-1:0][SEL_W-1:0]  src_sel;
    logic [NUM_PROD-1:0]            prod_valid;
    logic [NUM_PROD-1:0][OPC_W-1:0] prod_op;
    logic [NUM_PROD-1:0][REG_W-1:0] prod_dst;
    logic                           load_use;
    logic                           branch_flush;

    always_comb begin
        src_num[0]  = id_src1;
        src_num[1]  = id_src2;
        src_live[0] = id_valid && op_reads1(id_op) && (id_src1 != '0);
        src_live[1] = id_valid && op_reads2(id_op) && (id_src2 != '0);
        prod_valid  = {wb_valid, mem_valid, ex_valid};
        prod_op     = {wb_op, mem_op, ex_op};
        prod_dst    = {wb_dst, mem_dst, ex_dst};
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzd_operand_fwd #(.REG_W(REG_W)) u_fwd (
            .src        (src_num[s]),
            .src_live   (src_live[s]),
            .prod_valid (prod_valid),
            .prod_op    (prod_op),
            .prod_dst   (prod_dst),
            .sel        (src_sel[s])
        );
    end

    assign fwd_sel1 = src_sel[0];
    assign fwd_sel2 = src_sel[1];

    hzd_load_use #(.REG_W(REG_W)) u_lu (
        .src      (src_num),
        .src_live (src_live),
        .ex_valid (ex_valid),
        .ex_op    (ex_op),
        .ex_dst   (ex_dst),
        .load_use (load_use)
    );

    assign branch_flush = ex_taken && ex_valid && (ex_op == OPC_BRANCH);

    hzd_action_ctl u_act (
        .load_use     (load_use),
        .branch_flush (branch_flush),
        .pc_hold      (pc_hold),
        .ifid_hold    (ifid_hold),
        .idex_bubble  (idex_bubble),
        .ifid_flush   (ifid_flush),
        .idex_flush   (idex_flush),
        .pc_redirect  (pc_redirect)
    );
endmodule

// File: rtl/hzd_fwd_unit_chk.sv
module hzd_fwd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             id_valid,
    input logic [2:0]       id_op,
    input logic [REG_W-1:0] id_src1,
    input logic [REG_W-1:0] id_src2,
    input logic             ex_valid,
    input logic [2:0]       ex_op,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_taken,
    input logic [1:0]       fwd_sel1,
    input logic [1:0]       fwd_sel2,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ifid_flush,
    input logic             idex_flush,
    input logic             pc_redirect
);
    always_comb begin
        AST_SRC1_R0_NO_FWD: assert (id_src1 != '0 || fwd_sel1 == 2'd0) else $error("src1 r0 forwarded"); // R4
        AST_SRC2_R0_NO_FWD: assert (id_src2 != '0 || fwd_sel2 == 2'd0) else $error("src2 r0 forwarded"); // R4
        AST_ALU_FWD_MATCH: assert (fwd_sel1 != 2'd1 || (ex_valid && ex_dst == id_src1)) else $error("alu bypass without match"); // R1
        AST_HOLD_GROUP: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble) else $error("hold outputs split"); // R5
        AST_FLUSH_GROUP: assert (ifid_flush == idex_flush && idex_flush == pc_redirect) else $error("flush outputs split"); // R7
        AST_HOLD_NEEDS_LOAD: assert (!pc_hold || (id_valid && ex_valid && ex_op == 3'd3)) else $error("hold without load"); // R5
        AST_FLUSH_NEEDS_BRANCH: assert (!pc_redirect || (ex_taken && ex_valid && ex_op == 3'd5)) else $error("redirect without branch"); // R8
        AST_FLUSH_NOT_HOLD: assert (!(pc_redirect && pc_hold)) else $error("hold during redirect"); // R7
        AST_IDLE_QUIET: assert (id_valid || (fwd_sel1 == 2'd0 && fwd_sel2 == 2'd0 && !pc_hold)) else $error("idle decode active"); // R9
    end
endmodule

bind hzd_fwd_unit hzd_fwd_unit_chk #(.REG_W(REG_W)) u_chk (
    .id_valid    (id_valid),
    .id_op       (id_op),
    .id_src1     (id_src1),
    .id_src2     (id_src2),
    .ex_valid    (ex_valid),
    .ex_op       (ex_op),
    .ex_dst      (ex_dst),
    .ex_taken    (ex_taken),
    .fwd_sel1    (fwd_sel1),
    .fwd_sel2    (fwd_sel2),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .idex_flush  (idex_flush),
    .pc_redirect (pc_redirect)
);

// File: tb/hzd_fwd_unit_tb_top.sv
module hzd_fwd_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    localparam logic [2:0] NOP = 3'd0;
    localparam logic [2:0] ALU = 3'd1;
    localparam logic [2:0] ALI = 3'd2;
    localparam logic [2:0] LD  = 3'd3;
    localparam logic [2:0] ST  = 3'd4;
    localparam logic [2:0] BR  = 3'd5;

    typedef struct packed {
        int         req;
        logic       idv; logic [2:0] idop; logic [RW-1:0] s1; logic [RW-1:0] s2;
        logic       exv; logic [2:0] exop; logic [RW-1:0] exd;
        logic       mv;  logic [2:0] mop;  logic [RW-1:0] md;
        logic       wv;  logic [2:0] wop;  logic [RW-1:0] wd;
        logic       tk;
        logic [1:0] e1;  logic [1:0] e2;   logic es; logic ef;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1, 1'b1,ALU,5'd3,5'd4,   1'b1,ALU,5'd3,  1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd1,2'd0,1'b0,1'b0}, // R1
        '{1, 1'b1,ALU,5'd5,5'd6,   1'b0,NOP,5'd0,  1'b1,ALU,5'd6,  1'b0,NOP,5'd0,  1'b0, 2'd0,2'd2,1'b0,1'b0}, // R1
        '{1, 1'b1,ALU,5'd7,5'd2,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b1,LD,5'd7,   1'b0, 2'd3,2'd0,1'b0,1'b0}, // R1
        '{1, 1'b1,ST,5'd2,5'd8,    1'b0,NOP,5'd0,  1'b1,ALU,5'd8,  1'b1,ALI,5'd2,  1'b0, 2'd3,2'd2,1'b0,1'b0}, // R1
        '{2, 1'b1,ALU,5'd9,5'd9,   1'b1,ALU,5'd9,  1'b1,ALI,5'd9,  1'b1,ALU,5'd9,  1'b0, 2'd1,2'd1,1'b0,1'b0}, // R2
        '{2, 1'b1,ALU,5'd9,5'd1,   1'b1,ALU,5'd1,  1'b1,ALU,5'd9,  1'b1,LD,5'd9,   1'b0, 2'd2,2'd1,1'b0,1'b0}, // R2
        '{2, 1'b1,BR,5'd10,5'd11,  1'b0,ALU,5'd10, 1'b1,LD,5'd11,  1'b1,ALU,5'd10, 1'b0, 2'd3,2'd2,1'b0,1'b0}, // R2
        '{3, 1'b1,ALU,5'd3,5'd3,   1'b1,ST,5'd3,   1'b1,BR,5'd3,   1'b0,ALU,5'd3,  1'b0, 2'd0,2'd0,1'b0,1'b0}, // R3
        '{3, 1'b1,ALU,5'd12,5'd12, 1'b1,3'd6,5'd12,1'b1,3'd7,5'd12,1'b1,NOP,5'd12, 1'b0, 2'd0,2'd0,1'b0,1'b0}, // R3
        '{4, 1'b1,ALU,5'd0,5'd0,   1'b1,ALU,5'd0,  1'b1,LD,5'd0,   1'b1,ALU,5'd0,  1'b0, 2'd0,2'd0,1'b0,1'b0}, // R4
        '{4, 1'b1,ALU,5'd0,5'd2,   1'b1,LD,5'd0,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd0,2'd0,1'b0,1'b0}, // R4
        '{5, 1'b1,ALU,5'd1,5'd4,   1'b1,LD,5'd4,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd0,2'd1,1'b1,1'b0}, // R5
        '{5, 1'b1,LD,5'd6,5'd6,    1'b1,LD,5'd6,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd1,2'd0,1'b1,1'b0}, // R5
        '{5, 1'b1,ST,5'd2,5'd13,   1'b1,LD,5'd13,  1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd0,2'd1,1'b1,1'b0}, // R5
        '{6, 1'b1,ALU,5'd4,5'd5,   1'b0,NOP,5'd0,  1'b1,LD,5'd4,   1'b0,NOP,5'd0,  1'b0, 2'd2,2'd0,1'b0,1'b0}, // R6
        '{6, 1'b1,ALU,5'd14,5'd15, 1'b1,ALI,5'd14, 1'b1,LD,5'd15,  1'b0,NOP,5'd0,  1'b0, 2'd1,2'd2,1'b0,1'b0}, // R6
        '{10,1'b1,ALI,5'd1,5'd4,   1'b1,LD,5'd4,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b0, 2'd0,2'd0,1'b0,1'b0}, // R10
        '{10,1'b1,NOP,5'd7,5'd7,   1'b1,LD,5'd7,   1'b1,ALU,5'd7,  1'b1,ALU,5'd7,  1'b0, 2'd0,2'd0,1'b0,1'b0}, // R10
        '{7, 1'b1,ALU,5'd2,5'd3,   1'b1,BR,5'd2,   1'b1,ALU,5'd3,  1'b0,NOP,5'd0,  1'b1, 2'd0,2'd2,1'b0,1'b1}, // R7
        '{7, 1'b0,NOP,5'd0,5'd0,   1'b1,BR,5'd5,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b1, 2'd0,2'd0,1'b0,1'b1}, // R7
        '{8, 1'b1,ALU,5'd4,5'd1,   1'b1,LD,5'd4,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b1, 2'd1,2'd0,1'b1,1'b0}, // R8
        '{8, 1'b1,ALU,5'd1,5'd2,   1'b1,ALU,5'd8,  1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b1, 2'd0,2'd0,1'b0,1'b0}, // R8
        '{8, 1'b1,ALU,5'd1,5'd2,   1'b0,BR,5'd8,   1'b0,NOP,5'd0,  1'b0,NOP,5'd0,  1'b1, 2'd0,2'd0,1'b0,1'b0}, // R8
        '{9, 1'b0,ALU,5'd4,5'd4,   1'b1,LD,5'd4,   1'b1,ALU,5'd4,  1'b1,ALU,5'd4,  1'b0, 2'd0,2'd0,1'b0,1'b0}  // R9
    };

    logic clk = 1'b0;
    logic id_valid, ex_valid, mem_valid, wb_valid, ex_taken;
    logic [2:0] id_op, ex_op, mem_op, wb_op;
    logic [RW-1:0] id_src1, id_src2, ex_dst, mem_dst, wb_dst;
    logic [1:0] fwd_sel1, fwd_sel2;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush, pc_redirect;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hzd_fwd_unit #(.REG_W(RW)) dut_i (
        .id_valid(id_valid), .id_op(id_op), .id_src1(id_src1), .id_src2(id_src2),
        .ex_valid(ex_valid), .ex_op(ex_op), .ex_dst(ex_dst),
        .mem_valid(mem_valid), .mem_op(mem_op), .mem_dst(mem_dst),
        .wb_valid(wb_valid), .wb_op(wb_op), .wb_dst(wb_dst),
        .ex_taken(ex_taken),
        .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush), .pc_redirect(pc_redirect)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        id_valid = v.idv; id_op = v.idop; id_src1 = v.s1; id_src2 = v.s2;
        ex_valid = v.exv; ex_op = v.exop; ex_dst = v.exd;
        mem_valid = v.mv; mem_op = v.mop; mem_dst = v.md;
        wb_valid = v.wv; wb_op = v.wop; wb_dst = v.wd;
        ex_taken = v.tk;
        #(CLK_PERIOD / 4);
    endtask

    task automatic check_vec(input vec_t v, input string req);
        int hold_all;
        int flush_all;
        hold_all  = (pc_hold && ifid_hold && idex_bubble) ? 1 :
                    (!pc_hold && !ifid_hold && !idex_bubble) ? 0 : 2;
        flush_all = (ifid_flush && idex_flush && pc_redirect) ? 1 :
                    (!ifid_flush && !idex_flush && !pc_redirect) ? 0 : 2;
        check(req, "fwd_sel1", int'(fwd_sel1), int'(v.e1));
        check(req, "fwd_sel2", int'(fwd_sel2), int'(v.e2));
        check(req, "hold group", hold_all, int'(v.es));
        check(req, "flush group", flush_all, int'(v.ef));
    endtask

    initial begin
        vec_t v;
        // idle state: nothing valid, all outputs low (R9)
        v = '{9, 1'b0,NOP,5'd0,5'd0, 1'b0,NOP,5'd0, 1'b0,NOP,5'd0, 1'b0,NOP,5'd0, 1'b0, 2'd0,2'd0,1'b0,1'b0};
        drive(v);
        check_vec(v, "R9");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check_vec(VECS[i], $sformatf("R%0d", VECS[i].req));
        end

        // sweep every register number through ALU-stage bypass; register 0 excluded (R4, R1)
        for (int r = 0; r < (1 << RW); r++) begin
            v = '{4, 1'b1,ALU,RW'(r),RW'(r), 1'b1,ALU,RW'(r), 1'b1,ALU,RW'(r), 1'b0,NOP,5'd0, 1'b0,
                  (r == 0) ? 2'd0 : 2'd1, (r == 0) ? 2'd0 : 2'd1, 1'b0, 1'b0};
            drive(v);
            check_vec(v, (r == 0) ? "R4" : "R1");
        end

        // undefined consumer classes read no source even under a load match (R10)
        for (int op = 6; op < 8; op++) begin
            v = '{10, 1'b1,3'(op),5'd9,5'd9, 1'b1,LD,5'd9, 1'b1,ALU,5'd9, 1'b0,NOP,5'd0, 1'b0, 2'd0,2'd0,1'b0,1'b0};
            drive(v);
            check_vec(v, "R10");
        end

        // undefined producer classes in every stage never bypass (R3)
        for (int op = 6; op < 8; op++) begin
            v = '{3, 1'b1,ALU,5'd17,5'd18, 1'b1,3'(op),5'd17, 1'b1,3'(op),5'd18, 1'b1,3'(op),5'd17, 1'b0,
                  2'd0,2'd0,1'b0,1'b0};
            drive(v);
            check_vec(v, "R3");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule